// File: doc/BRIEF.md
# Software-Loaded Translation Buffer with Zone Protection

This block translates virtual addresses to physical addresses through a fully associative table of 64 translation entries. Software fills the table itself, one 32-bit word at a time. The high word of an entry holds the virtual page, the page size, the valid flag and the storage attributes. The low word holds the physical page and the execute and write permissions. Each entry selects its own page size, from 1 KiB up to 16 MiB.

A lookup presents a virtual address together with the requester's mode (user or supervisor) and the access kind (instruction fetch, data load or data store). One cycle later the block returns the following:
- whether an entry matched;
- the translated physical address;
- the read and write permission that was granted;
- a fault code.

Permissions pass through a second layer. Each entry names one of 16 zones, and a 32-bit zone protection input assigns every zone a 2-bit mode. The zone mode can deny user access, defer to the entry's own permissions, or grant full access. On a miss the block also reports the faulting address and a syndrome word for the exception handler. The current process ID and the zone protection word are plain inputs.

Top module: `zp_tlb`

## Requirements
- R1: A table write uses only the low 6 bits of `wrIdx` as the entry number, so index 64+k writes entry k.
- R2: A high-word write (`wrHigh`=1) stores these fields into the entry:
  - the page-size code from bits 9:7;
  - the virtual page number from bits 31:10, with the bits that fall inside the page cleared;
  - the valid flag from bit 6;
  - the attribute byte from bits 7:0;
  - the current `pid`, captured at the time of the write.
- R3: A low-word write (`wrHigh`=0) stores the physical page from bits 31:10, execute permission from bit 9 and write permission from bit 8. On a hit, `rspPaddr` takes the physical page above the page-offset bits and the virtual address inside them.
- R4: An entry whose valid flag is clear never matches. A valid entry matches only if its stored ID equals `pid` or its stored ID is zero.
- R5: A page-size code n gives a page of 1 KiB × 4^n. Only address bits at and above bit 10+2n are compared.
- R6: The zone number is attribute bits 3:0. Zone z takes its mode from `zpr` bits [31-2z : 30-2z].
- R7: In zone mode 0, a user access gets fault code 2 with no read and no write permission. A supervisor access in mode 0 is treated as in modes 1 and 2.
- R8: In zone modes 1 and 2, the entry's own permissions decide the result:
  - a fetch from an entry without execute permission gets fault 2 with no permission;
  - a store to an entry without write permission gets fault 2 with read-only permission;
  - a load from such an entry succeeds with read-only permission;
  - an entry with write permission grants read and write.
- R9: In zone mode 3, every access succeeds with read and write permission.
- R10: The fault codes are 0 for success, 1 for a miss and 2 for a protection fault.
  - A miss returns `rspHit`=0, no permission, `rspPaddr`=0, and `rspMissAddr` equal to the looked-up address.
  - On a miss, `rspSyndrome` has bit 23 set for a data store and is zero for a load or a fetch.
  - On a hit, `rspMissAddr` and `rspSyndrome` are zero.
- R11: When several entries match, the entry with the lowest index supplies the result.
- R12: The response to a request arrives on the next cycle, marked by `rspValid`. After reset no entry is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Table word write strobe |
| wrHigh | input | 1 | 1 selects the high word of the entry, 0 the low word |
| wrIdx | input | 8 | Entry index operand (low 6 bits used) |
| wrData | input | 32 | Word written into the entry |
| pid | input | 8 | Current process ID |
| zpr | input | 32 | Zone protection word, 2 bits per zone |
| lkReq | input | 1 | Lookup request |
| lkVaddr | input | 32 | Virtual address to translate |
| lkUser | input | 1 | 1 for a user-mode access |
| lkFetch | input | 1 | 1 for an instruction fetch |
| lkStore | input | 1 | 1 for a data store |
| rspValid | output | 1 | Response valid, one cycle after lkReq |
| rspHit | output | 1 | An entry matched |
| rspPaddr | output | 32 | Translated address |
| rspRead | output | 1 | Read permission granted |
| rspWrite | output | 1 | Write permission granted |
| rspFault | output | 2 | 0 success, 1 miss, 2 protection fault |
| rspMissAddr | output | 32 | Faulting address on a miss |
| rspSyndrome | output | 32 | Syndrome on a miss, bit 23 for a store |

## Verification
The assertions check, on every response cycle, the invariants between the output fields:
- a miss carries fault code 1 and no permission;
- a hit never carries a miss address or a syndrome;
- write permission always comes with read permission;
- a protection fault never grants write;
- a response follows every request after exactly one cycle.

Only the bench's scenarios can show the rest, because it depends on what is actually stored in the table:
- the correct physical address for each page size;
- which zone mode applied;
- process ID filtering;
- lowest-index priority among overlapping entries;
- the one-to-one mapping of aliased indices onto entries.

// File: rtl/zp_tlb_pkg.sv
package zp_tlb_pkg;
  localparam int PID_W = 8;
  localparam int PN_W = 22;          // page-number bits 31:10
  localparam int SYND_STORE_BIT = 23;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_MISS = 2'd1,
    FLT_PROT = 2'd2
  } fault_e;

  typedef struct packed {
    logic             valid;
    logic [2:0]       sizeCode;
    logic [PN_W-1:0]  epn;
    logic [PID_W-1:0] pid;
    logic [7:0]       attr;
    logic [PN_W-1:0]  rpn;
    logic             ex;
    logic             wr;
  } entry_t;

  typedef struct packed {
    logic wrHi;
    logic wrLo;
    logic lkCap;
  } strobe_t;

  // Address mask keeping the bits above a page of 1 KiB * 4^code.
  function automatic logic [31:0] pageMask(input logic [2:0] code);
    int sh;
    sh = 10 + 2 * int'(code);
    return ~((32'd1 << sh) - 32'd1);
  endfunction
endpackage

// File: rtl/zp_tlb_ctrl.sv
module zp_tlb_ctrl
  import zp_tlb_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    wrEn,
  input  logic    wrHigh,
  input  logic    lkReq,
  output strobe_t strb,
  output logic    rspValid
);
  always_comb begin
    strb.wrHi  = wrEn & wrHigh;
    strb.wrLo  = wrEn & ~wrHigh;
    strb.lkCap = lkReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= lkReq;
  end

  // R12
  rsp_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkReq |=> rspValid);
  // R12
  rsp_spurious_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lkReq |=> !rspValid);
endmodule

// File: rtl/zp_tlb_dp.sv
module zp_tlb_dp
  import zp_tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [31:0]      wrData,
  input  logic [PID_W-1:0] pid,
  input  logic [31:0]      zpr,
  input  logic [31:0]      lkVaddr,
  input  logic             lkUser,
  input  logic             lkFetch,
  input  logic             lkStore,
  input  logic             rspValid,
  output logic             rspHit,
  output logic [31:0]      rspPaddr,
  output logic             rspRead,
  output logic             rspWrite,
  output logic [1:0]       rspFault,
  output logic [31:0]      rspMissAddr,
  output logic [31:0]      rspSyndrome
);
  localparam int SEL_W = $clog2(ENTRIES);

  entry_t tbl [ENTRIES];
  logic [SEL_W-1:0] wrSel;
  logic [31:0] hiMask;

  assign wrSel  = wrIdx[SEL_W-1:0];          // R1
  assign hiMask = pageMask(wrData[9:7]);

  // Table write port: two halves per entry.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
    end else begin
      if (strb.wrHi) begin                     // R2
        tbl[wrSel].valid    <= wrData[6];
        tbl[wrSel].sizeCode <= wrData[9:7];
        tbl[wrSel].epn      <= wrData[31:10] & hiMask[31:10];
        tbl[wrSel].pid      <= pid;
        tbl[wrSel].attr     <= wrData[7:0];
      end
      if (strb.wrLo) begin                     // R3
        tbl[wrSel].rpn <= wrData[31:10];
        tbl[wrSel].ex  <= wrData[9];
        tbl[wrSel].wr  <= wrData[8];
      end
    end
  end

  // Parallel match, one comparator per entry (R4, R5).
  logic [ENTRIES-1:0] hitVec;
  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    logic [31:0] msk;
    assign msk = pageMask(tbl[g].sizeCode);
    assign hitVec[g] = tbl[g].valid
                     && (tbl[g].pid == pid || tbl[g].pid == '0)
                     && (((lkVaddr[31:10] ^ tbl[g].epn) & msk[31:10]) == '0);
  end

  // Lowest index wins (R11).
  logic anyHit;
  logic [SEL_W-1:0] hitSel;
  always_comb begin
    anyHit = 1'b0;
    hitSel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        anyHit = 1'b1;
        hitSel = SEL_W'(i);
      end
    end
  end

  entry_t hitEnt;
  logic [31:0] hitMask, nPaddr, zShift;
  logic [1:0] zMode;
  logic nRd, nWr;
  fault_e nFlt;
  logic unusedBits;

  assign hitEnt     = tbl[hitSel];
  assign hitMask    = pageMask(hitEnt.sizeCode);
  assign nPaddr     = ({hitEnt.rpn, 10'b0} & hitMask) | (lkVaddr & ~hitMask);
  assign zShift     = zpr >> (5'd30 - {hitEnt.attr[3:0], 1'b0});   // R6
  assign zMode      = zShift[1:0];
  assign unusedBits = ^{wrIdx, hitEnt.attr[7:4]};

  // Zone and entry permission resolution (R7, R8, R9, R10).
  always_comb begin
    nRd  = 1'b0;
    nWr  = 1'b0;
    nFlt = FLT_NONE;
    if (!anyHit) begin
      nFlt = FLT_MISS;
    end else if (zMode == 2'd3) begin
      nRd = 1'b1;
      nWr = 1'b1;
    end else if (zMode == 2'd0 && lkUser) begin
      nFlt = FLT_PROT;
    end else if (lkFetch) begin
      if (!hitEnt.ex) nFlt = FLT_PROT;
      else begin
        nRd = 1'b1;
        nWr = hitEnt.wr;
      end
    end else begin
      nRd = 1'b1;
      nWr = hitEnt.wr;
      if (!hitEnt.wr && lkStore) nFlt = FLT_PROT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspHit      <= 1'b0;
      rspPaddr    <= '0;
      rspRead     <= 1'b0;
      rspWrite    <= 1'b0;
      rspFault    <= FLT_NONE;
      rspMissAddr <= '0;
      rspSyndrome <= '0;
    end else if (strb.lkCap) begin
      rspHit      <= anyHit;
      rspPaddr    <= anyHit ? nPaddr : 32'd0;
      rspRead     <= nRd;
      rspWrite    <= nWr;
      rspFault    <= nFlt;
      rspMissAddr <= anyHit ? 32'd0 : lkVaddr;
      rspSyndrome <= (!anyHit && !lkFetch && lkStore) ? (32'd1 << SYND_STORE_BIT) : 32'd0;
    end
  end

  // R10
  miss_perm_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspHit |-> rspFault == FLT_MISS && !rspRead && !rspWrite);
  // R10
  hit_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspHit |-> rspFault != FLT_MISS && rspSyndrome == 32'd0 && rspMissAddr == 32'd0);
  // R8
  write_has_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspWrite |-> rspRead);
  // R7
  prot_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspFault == FLT_PROT |-> !rspWrite);
endmodule

// File: rtl/zp_tlb.sv
module zp_tlb
  import zp_tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrHigh,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [31:0]      wrData,
  input  logic [7:0]       pid,
  input  logic [31:0]      zpr,
  input  logic             lkReq,
  input  logic [31:0]      lkVaddr,
  input  logic             lkUser,
  input  logic             lkFetch,
  input  logic             lkStore,
  output logic             rspValid,
  output logic             rspHit,
  output logic [31:0]      rspPaddr,
  output logic             rspRead,
  output logic             rspWrite,
  output logic [1:0]       rspFault,
  output logic [31:0]      rspMissAddr,
  output logic [31:0]      rspSyndrome
);
  strobe_t strb;

  zp_tlb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrHigh(wrHigh),
    .lkReq(lkReq), .strb(strb), .rspValid(rspValid)
  );

  zp_tlb_dp #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrIdx(wrIdx), .wrData(wrData),
    .pid(pid), .zpr(zpr), .lkVaddr(lkVaddr), .lkUser(lkUser),
    .lkFetch(lkFetch), .lkStore(lkStore), .rspValid(rspValid),
    .rspHit(rspHit), .rspPaddr(rspPaddr), .rspRead(rspRead),
    .rspWrite(rspWrite), .rspFault(rspFault), .rspMissAddr(rspMissAddr),
    .rspSyndrome(rspSyndrome)
  );
endmodule

// File: tb/zp_tlb_tb.sv
`timescale 1ns/1ps
module zp_tlb_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, wrHigh = 1'b0;
  logic [7:0] wrIdx = '0;
  logic [31:0] wrData = '0;
  logic [7:0] pid = '0;
  logic [31:0] zpr = '0;
  logic lkReq = 1'b0, lkUser = 1'b0, lkFetch = 1'b0, lkStore = 1'b0;
  logic [31:0] lkVaddr = '0;
  logic rspValid, rspHit, rspRead, rspWrite;
  logic [31:0] rspPaddr, rspMissAddr, rspSyndrome;
  logic [1:0] rspFault;

  int nVec = 0, nBad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  zp_tlb u_dut (.*);

  // Bench model of the table
  logic        mValid [64];
  logic [2:0]  mSize  [64];
  logic [31:0] mEpn   [64];
  logic [7:0]  mPid   [64];
  logic [7:0]  mAttr  [64];
  logic [31:0] mRpn   [64];
  logic        mEx    [64];
  logic        mWr    [64];

  function automatic logic [31:0] bmask(input int code);
    return ~((32'd1 << (10 + 2 * code)) - 32'd1);
  endfunction

  function automatic void calc(input logic [31:0] va, input logic u, input logic f,
      input logic s, output logic eHit, output logic [31:0] ePa, output logic eRd,
      output logic eWr, output logic [1:0] eFlt, output logic [31:0] eMa,
      output logic [31:0] eSy);
    int j;
    int z;
    int md;
    j = -1;
    for (int i = 63; i >= 0; i--)
      if (mValid[i] && (mPid[i] == pid || mPid[i] == 8'd0) &&
          ((va & bmask(int'(mSize[i]))) == mEpn[i])) j = i;
    eHit = (j >= 0); ePa = 0; eRd = 0; eWr = 0; eFlt = 0; eMa = 0; eSy = 0;
    if (j < 0) begin
      eFlt = 2'd1; eMa = va;
      if (!f && s) eSy = 32'h0080_0000;
      return;
    end
    ePa = (mRpn[j] & bmask(int'(mSize[j]))) | (va & ~bmask(int'(mSize[j])));
    z = int'(mAttr[j][3:0]);
    md = int'((zpr >> (30 - 2 * z)) & 32'd3);
    if (md == 3) begin eRd = 1; eWr = 1; end
    else if (md == 0 && u) eFlt = 2'd2;
    else if (f) begin
      if (mEx[j]) begin eRd = 1; eWr = mWr[j]; end else eFlt = 2'd2;
    end else begin
      eRd = 1; eWr = mWr[j];
      if (s && !mWr[j]) eFlt = 2'd2;
    end
  endfunction

  task automatic writeHi(input int idx, input logic [31:0] d);
    int k;
    @(negedge clk);
    wrEn = 1; wrHigh = 1; wrIdx = idx[7:0]; wrData = d;
    k = idx & 63;
    mValid[k] = d[6]; mSize[k] = d[9:7];
    mEpn[k] = {d[31:10], 10'b0} & bmask(int'(d[9:7]));
    mPid[k] = pid; mAttr[k] = d[7:0];
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic writeLo(input int idx, input logic [31:0] d);
    int k;
    @(negedge clk);
    wrEn = 1; wrHigh = 0; wrIdx = idx[7:0]; wrData = d;
    k = idx & 63;
    mRpn[k] = {d[31:10], 10'b0}; mEx[k] = d[9]; mWr[k] = d[8];
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic lookup(input string tag, input logic [31:0] va, input logic u,
      input logic f, input logic s);
    logic eHit, eRd, eWr;
    logic [31:0] ePa, eMa, eSy;
    logic [1:0] eFlt;
    @(negedge clk);
    lkReq = 1; lkVaddr = va; lkUser = u; lkFetch = f; lkStore = s;
    calc(va, u, f, s, eHit, ePa, eRd, eWr, eFlt, eMa, eSy);
    @(negedge clk);
    lkReq = 0;
    nVec++;
    if (rspValid !== 1'b1 || rspHit !== eHit || rspPaddr !== ePa || rspRead !== eRd ||
        rspWrite !== eWr || rspFault !== eFlt || rspMissAddr !== eMa || rspSyndrome !== eSy) begin
      nBad++;
      $display("FAIL %s va=%h: got v%0b h%0b pa=%h r%0b w%0b f%0d ma=%h sy=%h exp v1 h%0b pa=%h r%0b w%0b f%0d ma=%h sy=%h",
        tag, va, rspValid, rspHit, rspPaddr, rspRead, rspWrite, rspFault, rspMissAddr, rspSyndrome,
        eHit, ePa, eRd, eWr, eFlt, eMa, eSy);
    end
  endtask

  task automatic checkIdle(input string tag);
    @(negedge clk);
    nVec++;
    if (rspValid !== 1'b0) begin
      nBad++;
      $display("FAIL %s: rspValid got %0b exp 0", tag, rspValid);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < 64; i++) begin
      mValid[i] = 0; mSize[i] = 0; mEpn[i] = 0; mPid[i] = 0;
      mAttr[i] = 0; mRpn[i] = 0; mEx[i] = 0; mWr[i] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1;

    // R12 reset: empty table, data store miss
    zpr = 32'hFFFF_FFFF;
    lookup("R12", 32'h0000_1234, 0, 0, 1);
    checkIdle("R12");
    // R10 fetch miss: syndrome zero
    lookup("R10", 32'h0ABC_0000, 1, 1, 0);

    // R1: index 69 aliases entry 5 (valid bit 6, size 0, zone 0)
    writeHi(69, 32'h0000_1040);
    writeLo(69, 32'h0000_8300);
    lookup("R1", 32'h0000_1004, 0, 0, 1);
    lookup("R3", 32'h0000_13FF, 1, 1, 0);

    // R5/R2: size code 2 (16 KiB) at bits 9:7, EPN in-page bits cleared
    writeHi(6, 32'h0002_3D40);
    writeLo(6, 32'h00A5_4300);
    lookup("R5", 32'h0002_3ABC, 0, 0, 0);
    lookup("R2", 32'h0002_0000, 0, 0, 0);
    lookup("R10", 32'h0002_4000, 0, 0, 1);

    // R4: invalid entry ignored; PID filtering
    writeHi(7, 32'h0004_0000);
    writeLo(7, 32'h0000_0300);
    lookup("R4", 32'h0004_0010, 0, 0, 0);
    pid = 8'd3;
    writeHi(8, 32'h0005_0040);
    writeLo(8, 32'h0007_0300);
    pid = 8'd2;
    lookup("R4", 32'h0005_0010, 0, 0, 0);
    pid = 8'd3;
    lookup("R4", 32'h0005_0010, 0, 0, 0);
    pid = 8'd0;
    writeHi(9, 32'h0006_0040);
    writeLo(9, 32'h0009_0300);
    pid = 8'd9;
    lookup("R4", 32'h0006_0020, 1, 0, 1);

    // R6..R9: entry 10 in zone 5, no execute, no write
    pid = 8'd0;
    writeHi(10, 32'h0007_0045);
    writeLo(10, 32'h000B_0000);
    zpr = 32'h0;
    lookup("R7", 32'h0007_0000, 1, 0, 0);
    lookup("R7", 32'h0007_0000, 0, 0, 0);
    zpr = 32'd1 << 20;
    lookup("R8", 32'h0007_0004, 0, 0, 1);
    lookup("R8", 32'h0007_0004, 1, 0, 0);
    zpr = 32'd2 << 20;
    lookup("R8", 32'h0007_0008, 0, 1, 0);
    zpr = 32'd3 << 20;
    lookup("R9", 32'h0007_0008, 1, 1, 0);
    lookup("R9", 32'h0007_000C, 1, 0, 1);
    zpr = 32'hFFF3_FFFF;           // zone 6 = mode 0, others 3
    lookup("R6", 32'h0007_000C, 1, 0, 1);

    // R11: overlapping entries 20 and 12
    writeHi(20, 32'h0009_0040);
    writeLo(20, 32'h0011_0300);
    writeHi(12, 32'h0009_0040);
    writeLo(12, 32'h0022_0300);
    lookup("R11", 32'h0009_0123, 0, 0, 0);

    // Random mix
    for (int it = 0; it < 4000; it++) begin
      int op;
      op = int'($urandom % 10);
      if (it % 200 == 0) zpr = $urandom;
      if (op < 2) begin
        logic [31:0] d;
        d = $urandom;
        if (($urandom % 5) != 0) d[6] = 1'b1;
        pid = 8'($urandom % 4);
        writeHi(int'($urandom % 256), d);
      end else if (op < 4) begin
        writeLo(int'($urandom % 256), $urandom);
      end else begin
        int j;
        logic [31:0] va;
        logic f;
        j = int'($urandom % 64);
        va = (($urandom % 4) == 0) ? $urandom
             : (mEpn[j] | ($urandom & ~bmask(int'(mSize[j]))));
        if (($urandom % 3) == 0) pid = 8'($urandom % 4);
        f = 1'($urandom);
        lookup("R8", va, 1'($urandom), f, f ? 1'b0 : 1'($urandom));
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule